// File: doc/BRIEF.md
# Scoreboard Hazard Tracking Controller

This block is the central hazard bookkeeping for a pipeline that issues instructions in program order but lets them execute and finish out of order. Each instruction moves through four steps: issue, operand read, execution and result write. The controller decides when each step may start. It keeps a status record per functional unit and a table that names, for every architectural register, the unit that will write it next. There is no forwarding and no renaming. A consumer gets a value only by reading the register file after the producer has written it back.

The decode stage presents one instruction at a time: target unit, operation code, destination and two source register numbers. The controller answers with an accept or a stall. A functional unit is told when it may read its operands. It later reports completion with a one-cycle done pulse. After that it is granted the result write once no other unit still needs the old register value. Every unit's recorded operation code is driven out so that the unit knows what to perform. Any table update made at a clock edge is seen by the issue and grant checks from the following cycle on.

Top module: `sb_ctrl`

## Requirements
- R1: An instruction presented with `iss_valid` is accepted (`iss_accept`=1, combinational in the same cycle) only when its target unit is not busy and its destination has no pending writer. On acceptance the unit becomes busy and its `fu_op` slice (bits `u*OP_W` upward) holds the operation code from the next cycle on.
- R2: An instruction whose destination register already has a pending writer is stalled, even when its target unit is free. It is accepted in the cycle after that writer's write grant.
- R3: A unit's operand read grant (`rd_gnt[u]`) is given only while both of its sources are ready. At most one read grant is given per cycle, and the lowest unit index wins. A unit receives exactly one read grant per instruction.
- R4: A source whose register had a pending writer at issue becomes ready in the cycle after that writer's write grant, so the consumer's read grant comes one cycle after the producer's write grant at the earliest.
- R5: An `ex_done[u]` pulse counts only while unit u is busy and has already had its read grant in an earlier cycle. Otherwise it is ignored. A counted pulse makes the unit eligible for a write grant from the next cycle.
- R6: A unit's write grant is withheld while any other busy unit still holds an unread, ready source whose register number equals this unit's destination.
- R7: At most one write grant (`wr_gnt[u]`) is given per cycle, and the lowest eligible unit index wins. A write grant frees the unit and clears its destination's pending-writer entry, both visible from the next cycle.
- R8: An instruction accepted in the same cycle as the write grant of its source's producer treats that source as ready. It receives its read grant in the next cycle.
- R9: After reset (`rst_n` low), every unit is free, no register has a pending writer, and no read or write grant is given.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| iss_valid | input | 1 | Decode stage presents an instruction |
| iss_unit | input | UIW | Target functional unit index |
| iss_op | input | OP_W | Operation code to record for the unit |
| iss_dst | input | RW | Destination register number |
| iss_src1 | input | RW | First source register number |
| iss_src2 | input | RW | Second source register number |
| iss_accept | output | 1 | Instruction taken this cycle (else stall) |
| rd_gnt | output | NUM_FU | Per-unit operand read grant |
| ex_done | input | NUM_FU | Per-unit execution complete pulse |
| wr_gnt | output | NUM_FU | Per-unit result write grant |
| fu_op | output | NUM_FU*OP_W | Recorded operation code of every unit |

## Verification
The bench uses the default parameters: four units, 32 registers and 4-bit operation codes. With one unit per instruction class, a six-instruction program of two loads, a multiply, a subtract, a divide and an add hits a structural stall, RAW waits, a read-priority collision and a write held back on a WAR hazard, all against hand-derived grant cycles. Directed sequences add a destination collision, completion pulses that must be ignored, a write grant and a dependent issue in the same cycle, and a reset in the middle of operation.

// File: rtl/sb_pkg.sv
// Shared helpers for the scoreboard controller.
// Assumes: all widths are derived from element counts through sb_idx_w.
package sb_pkg;

    // Index width needed to number n items, never below one bit.
    function automatic int sb_idx_w(input int n);
        return (n <= 2) ? 1 : $clog2(n);
    endfunction

endpackage

// File: rtl/sb_prio_pick.sv
// Fixed-priority picker: grants the lowest-indexed active request.
// Assumes: any request pattern; the result is one-hot or zero.
module sb_prio_pick #(
    parameter int N = 4
) (
    input  logic [N-1:0] req,
    output logic [N-1:0] gnt
);

    // Isolate the lowest set bit of the request vector.
    always_comb begin
        gnt = req & (~req + N'(1));
    end

endmodule

// File: rtl/sb_reg_status.sv
// Register result status: for each register, the code of the unit that
// will write it, or NONE_CODE. Three combinational lookups serve issue.
// Assumes: a clear and a set never target the same register in one cycle
// (issue stalls on a pending writer); the set wins if they ever do.
module sb_reg_status #(
    parameter int NUM_REG   = 32,
    parameter int RW        = 5,
    parameter int FUW       = 3,
    parameter int NONE_CODE = 4
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           set_en,
    input  logic [RW-1:0]  set_reg,
    input  logic [FUW-1:0] set_code,
    input  logic           clr_en,
    input  logic [RW-1:0]  clr_reg,
    input  logic [RW-1:0]  look_a,
    input  logic [RW-1:0]  look_b,
    input  logic [RW-1:0]  look_d,
    output logic [FUW-1:0] code_a,
    output logic [FUW-1:0] code_b,
    output logic [FUW-1:0] code_d
);

    localparam logic [FUW-1:0] NONE = FUW'(NONE_CODE);

    logic [FUW-1:0] owner [NUM_REG];

    // Record pending writers on issue and release them on write grant.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int r = 0; r < NUM_REG; r++) owner[r] <= NONE;
        end else begin
            if (clr_en) owner[clr_reg] <= NONE;
            if (set_en) owner[set_reg] <= set_code;
        end
    end

    // Lookups for both sources and the destination of the presented instruction.
    always_comb begin
        code_a = owner[look_a];
        code_b = owner[look_b];
        code_d = owner[look_d];
    end

endmodule

// File: rtl/sb_fu_slot.sv
// Status record of one functional unit: busy, operation, destination,
// sources, producer codes and ready flags, plus step progress flags.
// Assumes: issue_we only when the unit is free; wr_take only when the
// unit asked to write; producer codes at issue are already resolved
// against a write granted in the same cycle.
module sb_fu_slot #(
    parameter int RW        = 5,
    parameter int FUW       = 3,
    parameter int OP_W      = 4,
    parameter int NONE_CODE = 4
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            issue_we,
    input  logic [OP_W-1:0] issue_op,
    input  logic [RW-1:0]   issue_dst,
    input  logic [RW-1:0]   issue_s1,
    input  logic [RW-1:0]   issue_s2,
    input  logic [FUW-1:0]  issue_q1,
    input  logic [FUW-1:0]  issue_q2,
    input  logic            rd_take,
    input  logic            ex_done,
    input  logic            wr_take,
    input  logic            wr_any,
    input  logic [FUW-1:0]  wr_code,
    output logic            busy,
    output logic [OP_W-1:0] op,
    output logic [RW-1:0]   fi,
    output logic [RW-1:0]   fj,
    output logic [RW-1:0]   fk,
    output logic            rj,
    output logic            rk,
    output logic            rd_ready,
    output logic            wr_ready
);

    localparam logic [FUW-1:0] NONE = FUW'(NONE_CODE);

    logic [FUW-1:0] qj, qk;
    logic           read_seen, exec_seen;

    // Advance the unit through issue, operand read, completion and write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy      <= 1'b0;
            op        <= '0;
            fi        <= '0;
            fj        <= '0;
            fk        <= '0;
            qj        <= NONE;
            qk        <= NONE;
            rj        <= 1'b0;
            rk        <= 1'b0;
            read_seen <= 1'b0;
            exec_seen <= 1'b0;
        end else if (issue_we) begin
            busy      <= 1'b1;
            op        <= issue_op;
            fi        <= issue_dst;
            fj        <= issue_s1;
            fk        <= issue_s2;
            qj        <= issue_q1;
            qk        <= issue_q2;
            rj        <= (issue_q1 == NONE);
            rk        <= (issue_q2 == NONE);
            read_seen <= 1'b0;
            exec_seen <= 1'b0;
        end else if (wr_take) begin
            busy      <= 1'b0;
            qj        <= NONE;
            qk        <= NONE;
            rj        <= 1'b0;
            rk        <= 1'b0;
            read_seen <= 1'b0;
            exec_seen <= 1'b0;
        end else begin
            if (rd_take) begin
                rj        <= 1'b0;
                rk        <= 1'b0;
                read_seen <= 1'b1;
            end else begin
                if (wr_any && (qj == wr_code)) begin
                    rj <= 1'b1;
                    qj <= NONE;
                end
                if (wr_any && (qk == wr_code)) begin
                    rk <= 1'b1;
                    qk <= NONE;
                end
            end
            if (ex_done && busy && read_seen) exec_seen <= 1'b1;
        end
    end

    // Requests toward the read and write arbiters.
    always_comb begin
        rd_ready = busy && !read_seen && rj && rk;
        wr_ready = busy && exec_seen;
    end

endmodule

// File: rtl/sb_ctrl.sv
// Scoreboard controller top: in-order issue with structural and WAW
// stalls, operand read gated on RAW readiness, result write gated on WAR
// freedom. One read grant and one write grant per cycle, lowest unit first.
// Assumes: a unit pulses ex_done only after its read grant; the register
// file is read on rd_gnt and written on wr_gnt outside this block.
module sb_ctrl #(
    parameter int NUM_FU  = 4,
    parameter int NUM_REG = 32,
    parameter int OP_W    = 4,
    localparam int UIW    = sb_pkg::sb_idx_w(NUM_FU),
    localparam int RW     = sb_pkg::sb_idx_w(NUM_REG)
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   iss_valid,
    input  logic [UIW-1:0]         iss_unit,
    input  logic [OP_W-1:0]        iss_op,
    input  logic [RW-1:0]          iss_dst,
    input  logic [RW-1:0]          iss_src1,
    input  logic [RW-1:0]          iss_src2,
    output logic                   iss_accept,
    output logic [NUM_FU-1:0]      rd_gnt,
    input  logic [NUM_FU-1:0]      ex_done,
    output logic [NUM_FU-1:0]      wr_gnt,
    output logic [NUM_FU*OP_W-1:0] fu_op
);

    localparam int FUW = sb_pkg::sb_idx_w(NUM_FU + 1);
    localparam logic [FUW-1:0] NONE = FUW'(NUM_FU);

    logic [NUM_FU-1:0] busy, rj, rk, rd_ready, wr_ready, war_free, iss_we;
    logic [OP_W-1:0]   op_q [NUM_FU];
    logic [RW-1:0]     fi [NUM_FU];
    logic [RW-1:0]     fj [NUM_FU];
    logic [RW-1:0]     fk [NUM_FU];
    logic [FUW-1:0]    code_a, code_b, code_d, q_a, q_b, wr_code;
    logic [RW-1:0]     wr_dst;
    logic              wr_any;

    // Encode the single write grant into a unit code and its destination.
    always_comb begin
        wr_code = NONE;
        wr_dst  = '0;
        for (int u = 0; u < NUM_FU; u++) begin
            if (wr_gnt[u]) begin
                wr_code = FUW'(u);
                wr_dst  = fi[u];
            end
        end
        wr_any = |wr_gnt;
    end

    // Issue decision and producer codes, resolved against this cycle's write.
    always_comb begin
        iss_accept = iss_valid && (int'(iss_unit) < NUM_FU) &&
                     !busy[iss_unit] && (code_d == NONE);
        q_a = (wr_any && (code_a == wr_code)) ? NONE : code_a;
        q_b = (wr_any && (code_b == wr_code)) ? NONE : code_b;
        for (int u = 0; u < NUM_FU; u++) begin
            iss_we[u] = iss_accept && (int'(iss_unit) == u);
        end
    end

    // WAR check: a unit may write only if no busy unit still needs the old value.
    always_comb begin
        for (int u = 0; u < NUM_FU; u++) begin
            war_free[u] = 1'b1;
            for (int f = 0; f < NUM_FU; f++) begin
                if (busy[f] && rj[f] && (fj[f] == fi[u])) war_free[u] = 1'b0;
                if (busy[f] && rk[f] && (fk[f] == fi[u])) war_free[u] = 1'b0;
            end
        end
    end

    sb_reg_status #(
        .NUM_REG(NUM_REG), .RW(RW), .FUW(FUW), .NONE_CODE(NUM_FU)
    ) u_regstat (
        .clk(clk), .rst_n(rst_n),
        .set_en(iss_accept), .set_reg(iss_dst), .set_code(FUW'(iss_unit)),
        .clr_en(wr_any), .clr_reg(wr_dst),
        .look_a(iss_src1), .look_b(iss_src2), .look_d(iss_dst),
        .code_a(code_a), .code_b(code_b), .code_d(code_d)
    );

    for (genvar g = 0; g < NUM_FU; g++) begin : g_slot
        sb_fu_slot #(
            .RW(RW), .FUW(FUW), .OP_W(OP_W), .NONE_CODE(NUM_FU)
        ) u_slot (
            .clk(clk), .rst_n(rst_n),
            .issue_we(iss_we[g]), .issue_op(iss_op), .issue_dst(iss_dst),
            .issue_s1(iss_src1), .issue_s2(iss_src2),
            .issue_q1(q_a), .issue_q2(q_b),
            .rd_take(rd_gnt[g]), .ex_done(ex_done[g]), .wr_take(wr_gnt[g]),
            .wr_any(wr_any), .wr_code(wr_code),
            .busy(busy[g]), .op(op_q[g]), .fi(fi[g]), .fj(fj[g]), .fk(fk[g]),
            .rj(rj[g]), .rk(rk[g]),
            .rd_ready(rd_ready[g]), .wr_ready(wr_ready[g])
        );
        assign fu_op[g*OP_W +: OP_W] = op_q[g];
    end

    sb_prio_pick #(.N(NUM_FU)) u_rd_pick (.req(rd_ready), .gnt(rd_gnt));
    sb_prio_pick #(.N(NUM_FU)) u_wr_pick (.req(wr_ready & war_free), .gnt(wr_gnt));

endmodule

// File: rtl/sb_ctrl_chk.sv
// Protocol checker for sb_ctrl, attached by bind.
// Assumes: observes ports plus the per-unit busy vector of the top.
module sb_ctrl_chk #(
    parameter int NUM_FU = 4,
    parameter int UIW    = 2,
    parameter int RW     = 5
) (
    input logic              clk,
    input logic              rst_n,
    input logic              iss_accept,
    input logic [UIW-1:0]    iss_unit,
    input logic [RW-1:0]     iss_dst,
    input logic [NUM_FU-1:0] rd_gnt,
    input logic [NUM_FU-1:0] wr_gnt,
    input logic [NUM_FU-1:0] busy
);

    a_r3_single_read: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(rd_gnt));

    a_r7_single_write: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(wr_gnt));

    a_r1_issue_takes_unit: assert property (@(posedge clk) disable iff (!rst_n)
        iss_accept |=> busy[$past(iss_unit)]);

    a_r2_no_second_writer: assert property (@(posedge clk) disable iff (!rst_n)
        iss_accept |=> !(iss_accept && (iss_dst == $past(iss_dst))));

    for (genvar u = 0; u < NUM_FU; u++) begin : g_unit
        a_r7_write_frees: assert property (@(posedge clk) disable iff (!rst_n)
            wr_gnt[u] |=> !busy[u]);
        a_r3_read_once: assert property (@(posedge clk) disable iff (!rst_n)
            rd_gnt[u] |=> !rd_gnt[u]);
    end

endmodule

bind sb_ctrl sb_ctrl_chk #(.NUM_FU(NUM_FU), .UIW(UIW), .RW(RW)) u_chk (
    .clk(clk), .rst_n(rst_n), .iss_accept(iss_accept), .iss_unit(iss_unit),
    .iss_dst(iss_dst), .rd_gnt(rd_gnt), .wr_gnt(wr_gnt), .busy(busy)
);

// File: tb/sb_ctrl_tb.sv
module sb_ctrl_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        iss_valid = 1'b0;
    logic [1:0]  iss_unit = '0;
    logic [3:0]  iss_op = '0;
    logic [4:0]  iss_dst = '0, iss_src1 = '0, iss_src2 = '0;
    logic        iss_accept;
    logic [3:0]  rd_gnt, wr_gnt, ex_done = '0;
    logic [15:0] fu_op;

    int n_chk = 0, n_fail = 0;
    bit finished = 0;

    always #10 clk = ~clk;

    sb_ctrl u_dut (
        .clk(clk), .rst_n(rst_n), .iss_valid(iss_valid), .iss_unit(iss_unit),
        .iss_op(iss_op), .iss_dst(iss_dst), .iss_src1(iss_src1),
        .iss_src2(iss_src2), .iss_accept(iss_accept), .rd_gnt(rd_gnt),
        .ex_done(ex_done), .wr_gnt(wr_gnt), .fu_op(fu_op)
    );

    typedef struct packed {
        logic [1:0] unit;
        logic [3:0] op;
        logic [4:0] dst, s1, s2;
        logic [7:0] t_iss, t_rd, t_wr;
    } ins_t;

    // Units: 0 load/int, 1 add/sub, 2 multiply, 3 divide. Expected cycles hand-derived.
    localparam ins_t PROG [6] = '{
        '{2'd0, 4'h1, 5'd6,  5'd2, 5'd0, 8'd0,  8'd1,  8'd3 },
        '{2'd0, 4'h1, 5'd2,  5'd3, 5'd0, 8'd4,  8'd5,  8'd7 },
        '{2'd2, 4'h3, 5'd0,  5'd2, 5'd4, 8'd5,  8'd9,  8'd16},
        '{2'd1, 4'h2, 5'd8,  5'd6, 5'd2, 8'd6,  8'd8,  8'd11},
        '{2'd3, 4'h4, 5'd10, 5'd0, 5'd6, 8'd7,  8'd17, 8'd22},
        '{2'd1, 4'h5, 5'd6,  5'd8, 5'd2, 8'd12, 8'd13, 8'd18}
    };
    localparam int LAT [4] = '{1, 2, 6, 4};

    task automatic check(input string tag, input string what, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s: got %0d expected %0d", tag, what, act, exp);
        end
    endtask

    task automatic drive(input logic v, input logic [1:0] u, input logic [3:0] op,
                         input logic [4:0] d, input logic [4:0] a, input logic [4:0] b,
                         input logic [3:0] exd);
        @(negedge clk);
        iss_valid = v; iss_unit = u; iss_op = op;
        iss_dst = d; iss_src1 = a; iss_src2 = b; ex_done = exd;
        #1;
    endtask

    task automatic idle(input logic [3:0] exd);
        drive(1'b0, 2'd0, 4'h0, 5'd0, 5'd0, 5'd0, exd);
    endtask

    initial begin
        int iss_at [6];
        int rd_at [6];
        int wr_at [6];
        int owner [4];
        int done_at [4];
        int nxt;

        repeat (3) @(posedge clk);
        @(negedge clk); rst_n = 1'b1;
        #1;
        // R9: reset state
        check("R9", "rd_gnt after reset", rd_gnt, 0);
        check("R9", "wr_gnt after reset", wr_gnt, 0);
        check("R9", "accept with no valid", iss_accept, 0);

        for (int i = 0; i < 6; i++) begin iss_at[i] = -1; rd_at[i] = -1; wr_at[i] = -1; end
        for (int u = 0; u < 4; u++) begin owner[u] = 0; done_at[u] = -1; end
        nxt = 0;

        for (int cyc = 0; cyc < 30; cyc++) begin
            logic [3:0] exd;
            for (int u = 0; u < 4; u++) exd[u] = (done_at[u] == cyc);
            if (nxt < 6)
                drive(1'b1, PROG[nxt].unit, PROG[nxt].op, PROG[nxt].dst,
                      PROG[nxt].s1, PROG[nxt].s2, exd);
            else
                idle(exd);
            for (int u = 0; u < 4; u++) begin
                if (rd_gnt[u]) begin rd_at[owner[u]] = cyc; done_at[u] = cyc + LAT[u]; end
                if (wr_gnt[u]) wr_at[owner[u]] = cyc;
            end
            if (iss_accept && nxt < 6) begin
                iss_at[nxt] = cyc;
                owner[PROG[nxt].unit] = nxt;
                nxt++;
            end
        end

        for (int i = 0; i < 6; i++) begin
            check("R1", $sformatf("issue cycle of instr %0d", i), iss_at[i], int'(PROG[i].t_iss));
            check("R4", $sformatf("read cycle of instr %0d", i), rd_at[i], int'(PROG[i].t_rd));
            check("R6", $sformatf("write cycle of instr %0d", i), wr_at[i], int'(PROG[i].t_wr));
        end
        // R6: add overwrites r6 only after the divide has read it
        check("R6", "add write after divide read", int'(wr_at[5] > rd_at[4]), 1);
        // R3: subtract (unit 1) read before multiply (unit 2) on collision
        check("R3", "lower unit read first", int'(rd_at[3] < rd_at[2]), 1);

        // R5: completion pulse on an idle unit is ignored
        idle(4'b1000);
        check("R5", "wr_gnt after idle done", wr_gnt, 0);
        drive(1'b1, 2'd0, 4'h7, 5'd5, 5'd1, 5'd1, 4'b0000);
        check("R1", "accept free unit", iss_accept, 1);
        check("R5", "wr_gnt after idle done, next", wr_gnt, 0);
        idle(4'b0001);
        check("R3", "read grant unit 0", rd_gnt, 4'b0001);
        idle(4'b0000);
        check("R5", "done with read grant ignored", wr_gnt, 0);
        idle(4'b0001);
        check("R5", "no write in done cycle", wr_gnt, 0);
        idle(4'b0000);
        check("R7", "write after counted done", wr_gnt, 4'b0001);

        // R2: destination collision
        drive(1'b1, 2'd2, 4'h3, 5'd7, 5'd1, 5'd1, 4'b0000);
        check("R1", "accept mul to r7", iss_accept, 1);
        drive(1'b1, 2'd1, 4'h2, 5'd7, 5'd1, 5'd1, 4'b0000);
        check("R2", "stall on pending r7", iss_accept, 0);
        check("R3", "mul read grant", rd_gnt, 4'b0100);
        drive(1'b1, 2'd1, 4'h2, 5'd7, 5'd1, 5'd1, 4'b0100);
        check("R2", "still stalled", iss_accept, 0);
        drive(1'b1, 2'd1, 4'h2, 5'd7, 5'd1, 5'd1, 4'b0000);
        check("R7", "mul write grant", wr_gnt, 4'b0100);
        check("R2", "stall in writer's grant cycle", iss_accept, 0);
        drive(1'b1, 2'd1, 4'h2, 5'd7, 5'd1, 5'd1, 4'b0000);
        check("R2", "accept after writer done", iss_accept, 1);
        idle(4'b0000);
        check("R3", "add read grant", rd_gnt, 4'b0010);
        idle(4'b0010);
        idle(4'b0000);
        check("R7", "add write grant", wr_gnt, 4'b0010);

        // R8: dependent issue in the producer's write cycle
        drive(1'b1, 2'd3, 4'hD, 5'd9, 5'd1, 5'd1, 4'b0000);
        check("R1", "accept div to r9", iss_accept, 1);
        idle(4'b0000);
        check("R3", "div read grant", rd_gnt, 4'b1000);
        check("R1", "div op recorded", fu_op[15:12], 4'hD);
        idle(4'b1000);
        drive(1'b1, 2'd0, 4'h1, 5'd11, 5'd9, 5'd9, 4'b0000);
        check("R7", "div write grant", wr_gnt, 4'b1000);
        check("R8", "dependent accepted", iss_accept, 1);
        idle(4'b0000);
        check("R8", "dependent reads next cycle", rd_gnt, 4'b0001);
        idle(4'b0001);
        idle(4'b0000);
        check("R7", "dependent writes", wr_gnt, 4'b0001);

        // R9: reset during operation clears units and pending writers
        drive(1'b1, 2'd2, 4'h3, 5'd12, 5'd1, 5'd1, 4'b0000);
        check("R1", "accept before reset", iss_accept, 1);
        @(negedge clk); iss_valid = 1'b0; rst_n = 1'b0;
        @(negedge clk); rst_n = 1'b1; #1;
        check("R9", "no read grant after reset", rd_gnt, 0);
        drive(1'b1, 2'd2, 4'h3, 5'd12, 5'd1, 5'd1, 4'b0000);
        check("R9", "unit and r12 free after reset", iss_accept, 1);
        idle(4'b0000);

        finished = 1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!finished) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

endmodule